// File: doc/BRIEF.md
# Shortened Polar Transform Engine

This block is the transform core of a flash page codec built on a polar code whose mother length is a power of two. In encode mode it takes a serial stream of user bits and places them in the free slots of an N-bit working vector. The free slots are the indices that are neither frozen nor part of the shortened tail. It fills the frozen slots and the tail with zeros and multiplies the vector by the Kronecker-power generator, using a bank of XOR butterflies over log2(N) stages. It then streams out only the first N-K' codeword bits. The last K' codeword bits are always zero, so they are neither sent nor stored.

In inverse mode the block takes N-K' bits read back from the medium, which may be arbitrary data, and pads them with K' zeros. It then runs the same butterfly network, because the generator is its own inverse over GF(2), and streams out the full N-bit input vector. This lets data the encoder never produced be treated as a codeword. A sticky flag reports whether any recovered bit at a frozen or shortened index is nonzero.

Both data streams are one bit per cycle with valid/ready handshakes. A transfer happens only in a cycle where valid and ready are both high. The block never drops or repeats a bit under back-pressure. Once out_valid is high, it stays high with out_bit unchanged until out_ready accepts the bit. in_ready does not depend on in_valid, and out_valid does not depend on out_ready.

Top module: `polar_shortened_xform`

## Requirements
- R1: After reset, in_ready, out_valid, done and frozen_err are all low.
- R2: In encode mode (inv_mode=0 at start), output bit j equals the XOR of u[i] over every i whose binary index contains all the set bits of j, that is (i & j) == j. Here u is the assembled input vector. Output bits leave in ascending j order.
- R3: In encode mode the user bits fill, in ascending index order, only the indices below N-K' whose FROZEN_MASK bit is 0. Frozen indices hold 0. The engine takes exactly that many bits from the input stream before it transforms.
- R4: In encode mode exactly N-K' output bits are produced. Codeword indices N-K' through N-1 are never emitted.
- R5: In inverse mode (inv_mode=1 at start) the engine takes N-K' bits x[0..N-K'-1] and sets x[N-K'..N-1]=0. It then emits N bits u[0..N-1], in ascending order, using the same XOR rule as R2.
- R6: After an inverse run, frozen_err is 1 exactly when some emitted u[i] is 1 at an index that is frozen or at or above N-K'. The flag holds until the next accepted start.
- R7: An encode run leaves frozen_err at 0, even when the previous inverse run had set it.
- R8: Back-pressure on either stream, in any pattern, changes no emitted bit. While out_valid is high and out_ready is low, out_valid and out_bit stay stable.
- R9: done is a single-cycle pulse in the cycle right after the handshake of the last output bit.
- R10: A start pulse while a run is in progress is ignored, together with the inv_mode value that comes with it. It changes neither the run's mode nor its output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a run when the engine is idle |
| inv_mode | input | 1 | Mode sampled at start: 0 encode, 1 inverse |
| in_valid | input | 1 | Input bit available |
| in_ready | output | 1 | Engine accepts an input bit this cycle |
| in_bit | input | 1 | Serial input data |
| out_valid | output | 1 | Output bit available |
| out_ready | input | 1 | Downstream accepts the output bit |
| out_bit | output | 1 | Serial output data |
| done | output | 1 | Pulse after the final output transfer |
| frozen_err | output | 1 | Inverse run found a nonzero bit at a frozen or shortened index |

## Verification
A corrupted working-vector bit or a wrong butterfly pairing does not show up until the drain phase. It then appears as wrong output bits. In encode mode the error spreads to every lower index that is a subset of the bad index, so a single fault usually disturbs several emitted bits. A fault in the slot decoding shows up earlier, at the input port, as a wrong number of accepted bits. It also shows up later as a misplaced user bit and a wrong output count. A fault in the counters moves the done pulse away from the last output handshake. Running every encode input word, plus a spread of inverse patterns under random stalls, exposes each of these within a single run.

// File: rtl/polar_pkg.sv
package polar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_XFORM = 2'd2,
    ST_DRAIN = 2'd3
  } xf_state_e;
endpackage

// File: rtl/xf_slots.sv
// Classifies a vector index: whether it is filled from the input stream,
// and whether it is a reserved (frozen or shortened) index.
module xf_slots #(
  parameter int unsigned M = 5,
  parameter int unsigned SHORT_LEN = 3,
  parameter logic [(2**M)-1:0] FROZEN_MASK = '0
) (
  input  logic         inv_q,
  input  logic [M-1:0] idx,
  output logic         take,
  output logic         reserved
);
  localparam int unsigned N = 2 ** M;
  localparam int unsigned KEEP = N - SHORT_LEN;
  localparam logic [M:0] KEEP_W = (M+1)'(KEEP);

  logic in_kept;

  always_comb begin
    in_kept  = ({1'b0, idx} < KEEP_W);
    reserved = FROZEN_MASK[idx] || !in_kept;
    take     = inv_q ? in_kept : (in_kept && !FROZEN_MASK[idx]);
  end
endmodule

// File: rtl/xf_lanes.sv
// LANES parallel butterflies of one stage: pair p at span 2^stage maps to
// indices a (bit 'stage' clear) and b = a + 2^stage; a takes a^b, b is kept.
module xf_lanes #(
  parameter int unsigned M = 5,
  parameter int unsigned LANES = 4,
  parameter int unsigned SW = 3,
  parameter int unsigned CW = 2
) (
  input  logic [(2**M)-1:0] vec,
  input  logic [SW-1:0]     stage,
  input  logic [CW-1:0]     chunk,
  output logic [M-1:0]      a_idx [LANES],
  output logic              a_new [LANES]
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    int unsigned p, lo, hi, a, b;
    always_comb begin
      p  = int'(chunk) * LANES + l;
      lo = p & ((32'd1 << stage) - 32'd1);
      hi = p >> stage;
      a  = (hi << (stage + 1)) | lo;
      b  = a + (32'd1 << stage);
      a_idx[l] = M'(a);
      a_new[l] = vec[M'(a)] ^ vec[M'(b)];
    end
  end
endmodule

// File: rtl/xf_seq.sv
// Run sequencer: load walk, stage/chunk passes, drain walk, done pulse.
module xf_seq
  import polar_pkg::*;
#(
  parameter int unsigned M = 5,
  parameter int unsigned SHORT_LEN = 3,
  parameter int unsigned LANES = 4,
  parameter int unsigned SW = 3,
  parameter int unsigned CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          inv_mode,
  input  logic          in_valid,
  input  logic          out_ready,
  input  logic          take,
  output logic          in_ready,
  output logic          out_valid,
  output logic          done,
  output logic          inv_q,
  output logic [M-1:0]  idx,
  output logic          start_acc,
  output logic          load_we,
  output logic          xf_en,
  output logic [SW-1:0] stage,
  output logic [CW-1:0] chunk
);
  localparam int unsigned N = 2 ** M;
  localparam int unsigned KEEP = N - SHORT_LEN;
  localparam int unsigned CHUNKS = (N / 2) / LANES;
  localparam logic [M-1:0] LAST_IDX = M'(N - 1);
  localparam logic [M-1:0] LAST_ENC = M'(KEEP - 1);
  localparam logic [CW-1:0] LAST_CHUNK = CW'(CHUNKS - 1);
  localparam logic [SW-1:0] LAST_STAGE = SW'(M - 1);

  xf_state_e state;
  logic [M-1:0] last_out;
  logic out_fire, load_adv;

  always_comb begin
    start_acc = (state == ST_IDLE) && start;
    in_ready  = (state == ST_LOAD) && take;
    load_we   = in_ready && in_valid;
    load_adv  = (state == ST_LOAD) && (!take || in_valid);
    xf_en     = (state == ST_XFORM);
    out_valid = (state == ST_DRAIN);
    out_fire  = out_valid && out_ready;
    last_out  = inv_q ? LAST_IDX : LAST_ENC;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      inv_q <= 1'b0;
      idx   <= '0;
      stage <= '0;
      chunk <= '0;
      done  <= 1'b0;
    end else begin
      done <= out_fire && (idx == last_out);
      case (state)
        ST_IDLE: if (start_acc) begin
          state <= ST_LOAD;
          inv_q <= inv_mode;
          idx   <= '0;
        end
        ST_LOAD: if (load_adv) begin
          if (idx == LAST_IDX) begin
            state <= ST_XFORM;
            stage <= '0;
            chunk <= '0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        ST_XFORM: begin
          if (chunk == LAST_CHUNK) begin
            chunk <= '0;
            if (stage == LAST_STAGE) begin
              state <= ST_DRAIN;
              idx   <= '0;
            end else begin
              stage <= stage + 1'b1;
            end
          end else begin
            chunk <= chunk + 1'b1;
          end
        end
        ST_DRAIN: if (out_fire) begin
          if (idx == last_out) state <= ST_IDLE;
          else idx <= idx + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> out_valid);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R10
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(inv_q));
endmodule

// File: rtl/polar_shortened_xform.sv
module polar_shortened_xform #(
  parameter int unsigned M = 5,
  parameter int unsigned SHORT_LEN = 3,
  parameter int unsigned LANES = 4,
  parameter logic [(2**M)-1:0] FROZEN_MASK = {{((2**M)-8){1'b0}}, 8'h17}
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic inv_mode,
  input  logic in_valid,
  output logic in_ready,
  input  logic in_bit,
  output logic out_valid,
  input  logic out_ready,
  output logic out_bit,
  output logic done,
  output logic frozen_err
);
  localparam int unsigned N = 2 ** M;
  localparam int unsigned CHUNKS = (N / 2) / LANES;
  localparam int unsigned SW = (M > 1) ? $clog2(M) : 1;
  localparam int unsigned CW = (CHUNKS > 1) ? $clog2(CHUNKS) : 1;

  logic [N-1:0]  vec, vec_n;
  logic          inv_q, start_acc, load_we, xf_en, take, reserved;
  logic [M-1:0]  idx;
  logic [SW-1:0] stage;
  logic [CW-1:0] chunk;
  logic [M-1:0]  a_idx [LANES];
  logic          a_new [LANES];

  xf_seq #(.M(M), .SHORT_LEN(SHORT_LEN), .LANES(LANES), .SW(SW), .CW(CW)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .inv_mode(inv_mode),
    .in_valid(in_valid), .out_ready(out_ready), .take(take),
    .in_ready(in_ready), .out_valid(out_valid), .done(done),
    .inv_q(inv_q), .idx(idx), .start_acc(start_acc), .load_we(load_we),
    .xf_en(xf_en), .stage(stage), .chunk(chunk)
  );

  xf_slots #(.M(M), .SHORT_LEN(SHORT_LEN), .FROZEN_MASK(FROZEN_MASK)) u_slots (
    .inv_q(inv_q), .idx(idx), .take(take), .reserved(reserved)
  );

  xf_lanes #(.M(M), .LANES(LANES), .SW(SW), .CW(CW)) u_lanes (
    .vec(vec), .stage(stage), .chunk(chunk), .a_idx(a_idx), .a_new(a_new)
  );

  always_comb begin
    vec_n = vec;
    if (start_acc) begin
      vec_n = '0;
    end else if (load_we) begin
      vec_n[idx] = in_bit;
    end else if (xf_en) begin
      for (int l = 0; l < LANES; l++) vec_n[a_idx[l]] = a_new[l];
    end
  end

  assign out_bit = vec[idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec        <= '0;
      frozen_err <= 1'b0;
    end else begin
      vec <= vec_n;
      if (start_acc) frozen_err <= 1'b0;
      else if (out_valid && out_ready && inv_q && reserved && out_bit) frozen_err <= 1'b1;
    end
  end

  // R8
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> $stable(out_bit));
  // R7
  flag_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frozen_err) |-> inv_q);
endmodule

// File: tb/tb_polar_shortened_xform.sv
module tb_polar_shortened_xform;
  localparam int M = 4;
  localparam int N = 16;
  localparam int SL = 3;
  localparam int KEEP = N - SL;
  localparam logic [15:0] FRZ = 16'h0117;   // frozen: 0,1,2,4,8
  localparam logic [15:0] TAIL = 16'hE000;  // shortened: 13,14,15

  logic clk = 0, rst_n = 0, start = 0, inv_mode = 0;
  logic in_valid = 0, in_bit = 0, out_ready = 0;
  logic in_ready, out_valid, out_bit, done, frozen_err;
  int checks = 0, errors = 0;
  logic [15:0] lf = 16'hACE1;

  always #10 clk = ~clk;

  polar_shortened_xform #(.M(M), .SHORT_LEN(SL), .LANES(2), .FROZEN_MASK(FRZ)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .inv_mode(inv_mode),
    .in_valid(in_valid), .in_ready(in_ready), .in_bit(in_bit),
    .out_valid(out_valid), .out_ready(out_ready), .out_bit(out_bit),
    .done(done), .frozen_err(frozen_err));

  function automatic logic [15:0] xf(input logic [15:0] u);
    logic [15:0] x = '0;
    for (int j = 0; j < N; j++)
      for (int i = 0; i < N; i++)
        if ((i & j) == j) x[j] ^= u[i];
    return x;
  endfunction

  function automatic logic [15:0] place(input logic [7:0] w);
    logic [15:0] u = '0;
    int k = 0;
    for (int i = 0; i < KEEP; i++)
      if (!FRZ[i]) begin u[i] = w[k]; k++; end
    return u;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(input bit inv, input logic [15:0] din, input int nin, input bit poke,
                     output logic [15:0] dout, output int nout, output int ntaken, output bit done_ok);
    int cyc = 0;
    bit fin = 0, last_out = 0, took_in, took_out;
    dout = '0; nout = 0; ntaken = 0; done_ok = 1;
    @(negedge clk); start = 1; inv_mode = inv;
    @(negedge clk); start = 0;
    while (!fin) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      in_valid = (ntaken < nin) && (lf[0] | lf[3]);
      in_bit = din[ntaken[3:0]];
      out_ready = lf[1] | lf[5];
      if (poke && cyc == 4) begin start = 1; inv_mode = !inv; end
      else start = 0;
      took_in = in_valid && in_ready;
      took_out = out_valid && out_ready;
      if (took_out && nout < N) begin dout[nout[3:0]] = out_bit; nout++; end
      if (took_in) ntaken++;
      last_out = took_out;
      @(negedge clk); cyc++;
      if (done) begin fin = 1; if (!last_out) done_ok = 0; end
      if (cyc > 400) fin = 1;
    end
    start = 0; in_valid = 0; out_ready = 0;
    @(negedge clk);
    if (done) done_ok = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] u, x, got, exp;
    int nout, ntk;
    bit dok;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!in_ready && !out_valid && !done && !frozen_err, "R1",
        {in_ready, out_valid, done, frozen_err}, 0);
    rst_n = 1;
    @(negedge clk);

    // Encode sweep over every user word
    for (int w = 0; w < 256; w++) begin
      u = place(8'(w));
      exp = xf(u) & ~TAIL;
      run(1'b0, {8'h00, 8'(w)}, 8, (w % 16) == 5, got, nout, ntk, dok);
      // R2 R3 R8 R10 codeword content under stalls and stray start
      chk(got == exp, "R2", got, exp);
      chk(ntk == 8, "R3", ntk, 8);
      chk(nout == KEEP, "R4", nout, KEEP);
      chk(dok, "R9", dok, 1);
      chk(!frozen_err, "R7", frozen_err, 0);
    end

    // Inverse sweep over a spread of stored patterns
    for (int p = 0; p < 400; p++) begin
      x = {3'b000, 13'((p * 2731 + 17) & 13'h1fff)};
      exp = xf(x);
      run(1'b1, x, KEEP, (p % 32) == 3, got, nout, ntk, dok);
      chk(got == exp, "R5", got, exp);
      chk(nout == N && ntk == KEEP, "R5", {nout[15:0], ntk[15:0]}, {16'(N), 16'(KEEP)});
      chk(frozen_err == (|(exp & (FRZ | TAIL))), "R6", frozen_err, |(exp & (FRZ | TAIL)));
      chk(dok, "R9", dok, 1);
    end

    // Round trip: encoded codewords come back with a clean flag
    for (int w = 0; w < 24; w++) begin
      u = place(8'(w * 11));
      x = xf(u) & ~TAIL;
      run(1'b1, x, KEEP, 1'b0, got, nout, ntk, dok);
      chk(got == u, "R5", got, u);
      chk(!frozen_err, "R6", frozen_err, 0);
    end

    // R6 flag persists after the run, R7 cleared by an encode
    run(1'b1, 16'h0001, KEEP, 1'b0, got, nout, ntk, dok);
    chk(frozen_err, "R6", frozen_err, 1);
    repeat (5) @(negedge clk);
    chk(frozen_err, "R6", frozen_err, 1);
    run(1'b0, 16'h00A5, 8, 1'b0, got, nout, ntk, dok);
    chk(!frozen_err, "R7", frozen_err, 0);
    chk(got == (xf(place(8'hA5)) & ~TAIL), "R2", got, xf(place(8'hA5)) & ~TAIL);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule